// File: doc/BRIEF.md
# Page-Table Entry Access/Dirty Flag Updater

This block finishes a hardware page-table walk once a leaf entry has been found and its permissions checked. It decides whether the leaf's accessed flag, or its dirty flag for a store, still has to be set. If neither flag needs setting, it completes at once. If one does, it either reports a page fault or sets the flags in memory itself with an atomic compare-and-swap. Which of the two it does depends on an enable bit for the active translation stage.

A walker hands over the leaf PTE, the table base, the VPN index at that level, the access type, the translation stage and a verdict on whether the PTE location may be written. The block then owns a single memory port that carries plain reads and compare-and-swap operations. If the swap loses to another writer, the block reads the entry again and runs every leaf check again before it retries. It reports completion with a status, the access type and the final PTE value. A walker must not release the original access before the OK completion arrives.

Top module: `pte_flag_updater`

## Requirements
- R1: A leaf with V (bit 0) set, A (bit 6) set, and either a non-store access or D (bit 7) set completes with status OK (0) and issues no memory transaction. Access codes are load 0, store 1, fetch 2.
- R2: An enabled update issues a compare-and-swap (mem_op 1) to address base + (vpn_idx << 3). Its compare value is the held PTE, and its write value is that PTE with A set, plus D for a store. The entry in memory ends up with exactly that value.
- R3: If the stage enable is 0 and an update is needed, the result is a page fault (status 1) with no memory transaction. Stage codes are single 0, G-stage 1, VS-stage 2. Stages 0 and 1 use the machine-level enable and stage 2 uses the hypervisor-level enable.
- R4: The hypervisor-level enable counts as 0 whenever the machine-level enable is 0.
- R5: If an update is needed and enabled but the PTE location is not writable, the block reports an access fault (status 2) and issues no write. done_acc carries the original access type.
- R6: A failed compare-and-swap (mem_rsp_ok 0) is followed by a read (mem_op 0) of the same address. The returned value is checked again and the update is retried.
- R7: If a re-read returns an entry with V clear, the block reports a page fault and does not write.
- R8: A store that has to set D waits, with no memory request, until store_nonspec is 1. An update that sets only A does not wait.
- R9: An OK result that follows an update is given only after a successful swap response. At most one memory transaction is outstanding at a time.
- R10: After reset the block is idle: req_ready 1, mem_valid 0, done_valid 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Leaf handed over |
| req_ready | output | 1 | Block idle, accepts a leaf |
| req_pte | input | 64 | Leaf PTE value |
| req_table_base | input | PA_W | Physical base of the table at this level |
| req_vpn_idx | input | IDX_W | VPN index at this level |
| req_acc | input | 2 | Access type (0 load, 1 store, 2 fetch) |
| req_stage | input | 2 | Stage (0 single, 1 G, 2 VS) |
| req_pte_wr_ok | input | 1 | PTE location passes write protection checks |
| store_nonspec | input | 1 | Current store is non-speculative |
| menv_hw_upd_en | input | 1 | Machine-level hardware update enable |
| henv_hw_upd_en | input | 1 | Hypervisor-level hardware update enable |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_op | output | 1 | 0 read, 1 compare-and-swap |
| mem_addr | output | PA_W | PTE address |
| mem_cmp | output | 64 | Compare value |
| mem_wdata | output | 64 | Swap value |
| mem_rsp_valid | input | 1 | Response valid |
| mem_rsp_data | input | 64 | Read data |
| mem_rsp_ok | input | 1 | Swap succeeded |
| done_valid | output | 1 | One-cycle completion pulse |
| done_status | output | 2 | 0 OK, 1 page fault, 2 access fault |
| done_acc | output | 2 | Access type of the finished leaf |
| done_pte | output | 64 | Final PTE value |

## Verification
The assertions assume that memory sends a response only while the block waits for one, and sends exactly one response per accepted request. They also assume that the walker raises req_valid only while req_ready is high. The bench's memory model answers each accepted request one cycle later, and the bench starts a new leaf only after the previous completion. Lost swaps are produced by having the model overwrite the entry just before it compares. The model always accepts at once, so it never breaks the request-stability property.

// File: rtl/pte_upd_pkg.sv
`timescale 1ns/1ps
package pte_upd_pkg;
  localparam int PTE_W  = 64;
  localparam int BIT_V  = 0;
  localparam int BIT_A  = 6;
  localparam int BIT_D  = 7;
  localparam int ENTRY_SHIFT = 3;

  typedef enum logic [1:0] {ACC_LOAD = 2'd0, ACC_STORE = 2'd1, ACC_FETCH = 2'd2} acc_e;
  typedef enum logic [1:0] {STG_SINGLE = 2'd0, STG_GUEST = 2'd1, STG_VS = 2'd2} stage_e;
  typedef enum logic [1:0] {RES_OK = 2'd0, RES_PF = 2'd1, RES_AF = 2'd2} res_e;
  typedef enum logic [1:0] {VD_DONE, VD_PF, VD_AF, VD_UPDATE} verdict_e;

  localparam logic OP_READ = 1'b0;
  localparam logic OP_CAS  = 1'b1;

  // Flags that must be set for this access type
  function automatic logic [PTE_W-1:0] flags_wanted(acc_e acc);
    logic [PTE_W-1:0] m;
    m = '0;
    m[BIT_A] = 1'b1;
    if (acc == ACC_STORE) m[BIT_D] = 1'b1;
    return m;
  endfunction

  function automatic logic flags_missing(logic [PTE_W-1:0] pte, acc_e acc);
    return (flags_wanted(acc) & ~pte) != '0;
  endfunction

  function automatic logic [PTE_W-1:0] flags_applied(logic [PTE_W-1:0] pte, acc_e acc);
    return pte | flags_wanted(acc);
  endfunction

  function automatic logic stage_hw_on(stage_e stg, logic m_en, logic h_en);
    return (stg == STG_VS) ? (h_en & m_en) : m_en;
  endfunction
endpackage

// File: rtl/pte_upd_judge.sv
`timescale 1ns/1ps
module pte_upd_judge
  import pte_upd_pkg::*;
(
  input  logic [PTE_W-1:0] pte,
  input  acc_e             acc,
  input  stage_e           stage,
  input  logic             wr_ok,
  input  logic             m_en,
  input  logic             h_en,
  output verdict_e         verdict,
  output logic [PTE_W-1:0] new_pte,
  output logic             dirty_needed
);
  logic hw_on;
  logic missing;

  always_comb begin
    hw_on        = stage_hw_on(stage, m_en, h_en);
    missing      = flags_missing(pte, acc);
    new_pte      = flags_applied(pte, acc);
    dirty_needed = (acc == ACC_STORE) && !pte[BIT_D];
    if (!pte[BIT_V])   verdict = VD_PF;
    else if (!missing) verdict = VD_DONE;
    else if (!hw_on)   verdict = VD_PF;
    else if (!wr_ok)   verdict = VD_AF;
    else               verdict = VD_UPDATE;
  end
endmodule

// File: rtl/pte_upd_seq.sv
`timescale 1ns/1ps
module pte_upd_seq
  import pte_upd_pkg::*;
#(
  parameter int PA_W = 56
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [PTE_W-1:0] req_pte,
  input  logic [PA_W-1:0]  req_addr,
  input  acc_e             req_acc,
  input  stage_e           req_stage,
  input  logic             req_wr_ok,
  input  logic             store_nonspec,
  input  verdict_e         verdict,
  input  logic [PTE_W-1:0] new_pte,
  input  logic             dirty_needed,
  output logic [PTE_W-1:0] held_pte,
  output acc_e             held_acc,
  output stage_e           held_stage,
  output logic             held_wr_ok,
  output logic             evaluating,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic             mem_op,
  output logic [PA_W-1:0]  mem_addr,
  output logic [PTE_W-1:0] mem_cmp,
  output logic [PTE_W-1:0] mem_wdata,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  input  logic             mem_rsp_ok,
  output logic             done_valid,
  output res_e             done_status
);
  typedef enum logic [2:0] {
    S_IDLE, S_EVAL, S_HOLD, S_CAS_REQ, S_CAS_WAIT, S_RD_REQ, S_RD_WAIT, S_DONE
  } st_e;

  st_e              st_q;
  logic [PTE_W-1:0] pte_q, wval_q;
  logic [PA_W-1:0]  addr_q;
  acc_e             acc_q;
  stage_e           stage_q;
  logic             wrok_q;
  res_e             res_q;

  // Named events for the checks below
  logic ev_accept, ev_eval_fault, ev_cas_win, ev_cas_lose, ev_reread;
  assign ev_accept     = (st_q == S_IDLE) && req_valid;
  assign ev_eval_fault = (st_q == S_EVAL) && (verdict == VD_PF || verdict == VD_AF);
  assign ev_cas_win    = (st_q == S_CAS_WAIT) && mem_rsp_valid && mem_rsp_ok;
  assign ev_cas_lose   = (st_q == S_CAS_WAIT) && mem_rsp_valid && !mem_rsp_ok;
  assign ev_reread     = (st_q == S_RD_WAIT) && mem_rsp_valid;

  assign req_ready   = (st_q == S_IDLE);
  assign evaluating  = (st_q == S_EVAL);
  assign held_pte    = pte_q;
  assign held_acc    = acc_q;
  assign held_stage  = stage_q;
  assign held_wr_ok  = wrok_q;
  assign mem_valid   = (st_q == S_CAS_REQ) || (st_q == S_RD_REQ);
  assign mem_op      = (st_q == S_CAS_REQ) ? OP_CAS : OP_READ;
  assign mem_addr    = addr_q;
  assign mem_cmp     = pte_q;
  assign mem_wdata   = wval_q;
  assign done_valid  = (st_q == S_DONE);
  assign done_status = res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      pte_q   <= '0;
      wval_q  <= '0;
      addr_q  <= '0;
      acc_q   <= ACC_LOAD;
      stage_q <= STG_SINGLE;
      wrok_q  <= 1'b0;
      res_q   <= RES_OK;
    end else begin
      unique case (st_q)
        S_IDLE: if (ev_accept) begin
          pte_q   <= req_pte;
          addr_q  <= req_addr;
          acc_q   <= req_acc;
          stage_q <= req_stage;
          wrok_q  <= req_wr_ok;
          st_q    <= S_EVAL;
        end
        S_EVAL: begin
          unique case (verdict)
            VD_DONE: begin res_q <= RES_OK; st_q <= S_DONE; end
            VD_PF:   begin res_q <= RES_PF; st_q <= S_DONE; end
            VD_AF:   begin res_q <= RES_AF; st_q <= S_DONE; end
            default: begin
              wval_q <= new_pte;
              st_q   <= (dirty_needed && !store_nonspec) ? S_HOLD : S_CAS_REQ;
            end
          endcase
        end
        S_HOLD:    if (store_nonspec) st_q <= S_CAS_REQ;
        S_CAS_REQ: if (mem_ready) st_q <= S_CAS_WAIT;
        S_CAS_WAIT: begin
          if (ev_cas_win) begin
            pte_q <= wval_q;
            res_q <= RES_OK;
            st_q  <= S_DONE;
          end else if (ev_cas_lose) begin
            st_q  <= S_RD_REQ;
          end
        end
        S_RD_REQ:  if (mem_ready) st_q <= S_RD_WAIT;
        S_RD_WAIT: if (ev_reread) begin
          pte_q <= mem_rsp_data;
          st_q  <= S_EVAL;
        end
        S_DONE:    st_q <= S_IDLE;
        default:   st_q <= S_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  localparam logic [PTE_W-1:0] AD_MASK = (PTE_W'(1) << BIT_A) | (PTE_W'(1) << BIT_D);

  p_cas_sets_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_op == OP_CAS) |-> (mem_wdata[BIT_A] && ((mem_wdata | AD_MASK) == (mem_cmp | AD_MASK))));

  p_fault_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_eval_fault |=> (done_valid && !mem_valid && done_status != RES_OK));

  p_lose_reread_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cas_lose |=> (mem_valid && mem_op == OP_READ && !done_valid));

  p_hold_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_HOLD && !store_nonspec) |=> !mem_valid);

  p_win_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cas_win |=> (done_valid && done_status == RES_OK));

  p_req_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_op)));

  p_rsp_expected_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> (st_q == S_CAS_WAIT || st_q == S_RD_WAIT));
endmodule

// File: rtl/pte_flag_updater.sv
`timescale 1ns/1ps
module pte_flag_updater
  import pte_upd_pkg::*;
#(
  parameter int PA_W  = 56,
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [63:0]      req_pte,
  input  logic [PA_W-1:0]  req_table_base,
  input  logic [IDX_W-1:0] req_vpn_idx,
  input  logic [1:0]       req_acc,
  input  logic [1:0]       req_stage,
  input  logic             req_pte_wr_ok,
  input  logic             store_nonspec,
  input  logic             menv_hw_upd_en,
  input  logic             henv_hw_upd_en,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic             mem_op,
  output logic [PA_W-1:0]  mem_addr,
  output logic [63:0]      mem_cmp,
  output logic [63:0]      mem_wdata,
  input  logic             mem_rsp_valid,
  input  logic [63:0]      mem_rsp_data,
  input  logic             mem_rsp_ok,
  output logic             done_valid,
  output logic [1:0]       done_status,
  output logic [1:0]       done_acc,
  output logic [63:0]      done_pte
);
  function automatic logic [PA_W-1:0] entry_addr(logic [PA_W-1:0] base, logic [IDX_W-1:0] idx);
    return base + (PA_W'(idx) << ENTRY_SHIFT);
  endfunction

  logic [PTE_W-1:0] held_pte, new_pte;
  acc_e             held_acc;
  stage_e           held_stage;
  logic             held_wr_ok, dirty_needed, evaluating;
  verdict_e         verdict;
  res_e             status;

  pte_upd_judge u_judge (
    .pte          (held_pte),
    .acc          (held_acc),
    .stage        (held_stage),
    .wr_ok        (held_wr_ok),
    .m_en         (menv_hw_upd_en),
    .h_en         (henv_hw_upd_en),
    .verdict      (verdict),
    .new_pte      (new_pte),
    .dirty_needed (dirty_needed)
  );

  pte_upd_seq #(.PA_W(PA_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_pte       (req_pte),
    .req_addr      (entry_addr(req_table_base, req_vpn_idx)),
    .req_acc       (acc_e'(req_acc)),
    .req_stage     (stage_e'(req_stage)),
    .req_wr_ok     (req_pte_wr_ok),
    .store_nonspec (store_nonspec),
    .verdict       (verdict),
    .new_pte       (new_pte),
    .dirty_needed  (dirty_needed),
    .held_pte      (held_pte),
    .held_acc      (held_acc),
    .held_stage    (held_stage),
    .held_wr_ok    (held_wr_ok),
    .evaluating    (evaluating),
    .mem_valid     (mem_valid),
    .mem_ready     (mem_ready),
    .mem_op        (mem_op),
    .mem_addr      (mem_addr),
    .mem_cmp       (mem_cmp),
    .mem_wdata     (mem_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .mem_rsp_ok    (mem_rsp_ok),
    .done_valid    (done_valid),
    .done_status   (status)
  );

  assign done_status = status;
  assign done_acc    = held_acc;
  assign done_pte    = held_pte;

  p_hyp_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (evaluating && verdict == VD_UPDATE && held_stage == STG_VS) |-> (menv_hw_upd_en && henv_hw_upd_en));

  p_unwritable_no_cas_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_op == OP_CAS) |-> held_wr_ok);
endmodule

// File: tb/tb_pte_flag_updater.sv
`timescale 1ns/1ps
module tb_pte_flag_updater;
  localparam int PA_W = 56;
  localparam int IDX_W = 9;
  localparam logic [PA_W-1:0] BASE = 56'h80_0000;

  localparam logic [63:0] P   = 64'h0000_0000_2000_0007;
  localparam logic [63:0] PA  = P | 64'h40;
  localparam logic [63:0] PD  = P | 64'h80;
  localparam logic [63:0] PAD = P | 64'hC0;
  localparam logic [63:0] P0  = P & ~64'h1;

  typedef struct packed {
    logic [63:0] pte; logic [8:0] idx; logic [1:0] acc; logic [1:0] stg;
    logic wr; logic men; logic hen; logic [1:0] st; logic [63:0] mem; logic [1:0] cas;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VT [0:NV-1] = '{
    '{P,   9'd1,  2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 2'd0, PA,  2'd1},  // R2
    '{P,   9'd2,  2'd1, 2'd0, 1'b1, 1'b1, 1'b0, 2'd0, PAD, 2'd1},  // R2
    '{PA,  9'd3,  2'd1, 2'd0, 1'b1, 1'b1, 1'b0, 2'd0, PAD, 2'd1},  // R2
    '{PAD, 9'd4,  2'd1, 2'd0, 1'b1, 1'b1, 1'b0, 2'd0, PAD, 2'd0},  // R1
    '{PA,  9'd5,  2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 2'd0, PA,  2'd0},  // R1
    '{P,   9'd6,  2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 2'd1, P,   2'd0},  // R3
    '{PA,  9'd7,  2'd1, 2'd1, 1'b1, 1'b0, 1'b1, 2'd1, PA,  2'd0},  // R3
    '{P,   9'd9,  2'd2, 2'd1, 1'b1, 1'b1, 1'b0, 2'd0, PA,  2'd1},  // R3
    '{P,   9'd10, 2'd2, 2'd2, 1'b1, 1'b1, 1'b0, 2'd1, P,   2'd0},  // R3
    '{P,   9'd11, 2'd0, 2'd2, 1'b1, 1'b1, 1'b1, 2'd0, PA,  2'd1},  // R3
    '{P,   9'd12, 2'd0, 2'd2, 1'b1, 1'b0, 1'b1, 2'd1, P,   2'd0},  // R4
    '{P,   9'd13, 2'd1, 2'd0, 1'b0, 1'b1, 1'b0, 2'd2, P,   2'd0},  // R5
    '{P,   9'd14, 2'd2, 2'd0, 1'b0, 1'b1, 1'b0, 2'd2, P,   2'd0},  // R5
    '{PA,  9'd15, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 2'd0, PA,  2'd0},  // R1
    '{P,   9'd16, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd1, P,   2'd0},  // R3
    '{P0,  9'd17, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 2'd1, P0,  2'd0},  // R7
    '{PD,  9'd18, 2'd1, 2'd2, 1'b1, 1'b1, 1'b1, 2'd0, PAD, 2'd1},  // R2
    '{P,   9'd19, 2'd1, 2'd1, 1'b1, 1'b1, 1'b0, 2'd0, PAD, 2'd1}   // R2
  };

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic req_valid = 0, req_ready;
  logic [63:0] req_pte = '0;
  logic [PA_W-1:0] req_table_base = BASE;
  logic [IDX_W-1:0] req_vpn_idx = '0;
  logic [1:0] req_acc = '0, req_stage = '0;
  logic req_pte_wr_ok = 0, store_nonspec = 1, menv_hw_upd_en = 0, henv_hw_upd_en = 0;
  logic mem_valid, mem_op, mem_ready = 1;
  logic [PA_W-1:0] mem_addr;
  logic [63:0] mem_cmp, mem_wdata, mem_rsp_data = '0;
  logic mem_rsp_valid = 0, mem_rsp_ok = 0;
  logic done_valid;
  logic [1:0] done_status, done_acc;
  logic [63:0] done_pte;

  pte_flag_updater #(.PA_W(PA_W), .IDX_W(IDX_W)) dut (.*);

  // memory model
  logic [63:0] mem_arr [8];
  logic interf_en = 0;
  logic [63:0] interf_val = '0;
  int cas_cnt = 0, rd_cnt = 0;
  logic [PA_W-1:0] last_addr = '0;

  initial begin
    forever begin
      @(posedge clk);
      mem_rsp_valid <= 1'b0;
      if (mem_valid && mem_ready) begin
        last_addr = mem_addr;
        if (mem_op) begin
          cas_cnt++;
          if (interf_en) begin mem_arr[mem_addr[5:3]] = interf_val; interf_en = 0; end
          if (mem_arr[mem_addr[5:3]] == mem_cmp) begin
            mem_arr[mem_addr[5:3]] = mem_wdata; mem_rsp_ok <= 1'b1;
          end else mem_rsp_ok <= 1'b0;
          mem_rsp_data <= '0;
        end else begin
          rd_cnt++;
          mem_rsp_data <= mem_arr[mem_addr[5:3]];
          mem_rsp_ok <= 1'b0;
        end
        mem_rsp_valid <= 1'b1;
      end
    end
  end

  int n_chk = 0, n_fail = 0;
  bit ended = 0;

  task automatic chk(input bit ok, input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // start a leaf: drive at negedge, accepted on next posedge
  task automatic start(input logic [63:0] pte, input logic [8:0] idx, input logic [1:0] acc,
                       input logic [1:0] stg, input logic wr);
    @(negedge clk);
    mem_arr[idx[2:0]] = pte;
    cas_cnt = 0; rd_cnt = 0;
    req_pte = pte; req_vpn_idx = idx; req_acc = acc; req_stage = stg; req_pte_wr_ok = wr;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_done(input int lim, output bit got);
    got = 0;
    for (int c = 0; c < lim && !got; c++) begin
      if (done_valid) got = 1; else @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    wrap_up();
  end

  initial begin
    bit got;
    for (int i = 0; i < 8; i++) mem_arr[i] = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(req_ready == 1, "R10", "req_ready in reset", 64'(req_ready), 64'd1);
    chk(mem_valid == 0 && done_valid == 0, "R10", "mem/done in reset", {mem_valid, done_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && mem_valid == 0 && done_valid == 0, "R10", "idle after reset",
        {req_ready, mem_valid, done_valid}, 64'b100);

    // table walk
    for (int v = 0; v < NV; v++) begin
      menv_hw_upd_en = VT[v].men; henv_hw_upd_en = VT[v].hen; store_nonspec = 1;
      start(VT[v].pte, VT[v].idx, VT[v].acc, VT[v].stg, VT[v].wr);
      wait_done(40, got);
      chk(got, "R9", $sformatf("vec%0d done seen", v), 64'(got), 64'd1);
      chk(done_status == VT[v].st, "R1/R3/R5", $sformatf("vec%0d status", v), 64'(done_status), 64'(VT[v].st));
      chk(mem_arr[VT[v].idx[2:0]] == VT[v].mem, "R2", $sformatf("vec%0d memory", v),
          mem_arr[VT[v].idx[2:0]], VT[v].mem);
      chk(cas_cnt == int'(VT[v].cas) && rd_cnt == 0, "R1", $sformatf("vec%0d transactions", v),
          64'(cas_cnt), 64'(VT[v].cas));
      if (VT[v].st == 2'd0)
        chk(done_pte == VT[v].mem, "R2", $sformatf("vec%0d done_pte", v), done_pte, VT[v].mem);
      if (VT[v].cas != 0)
        chk(last_addr == BASE + (PA_W'(VT[v].idx) << 3), "R2", $sformatf("vec%0d address", v),
            64'(last_addr), 64'(BASE + (PA_W'(VT[v].idx) << 3)));
      if (VT[v].st == 2'd2)
        chk(done_acc == VT[v].acc, "R5", $sformatf("vec%0d fault access type", v), 64'(done_acc), 64'(VT[v].acc));
      @(negedge clk);
    end

    // R8: store needing D waits for non-speculative qualification
    menv_hw_upd_en = 1; henv_hw_upd_en = 0; store_nonspec = 0;
    start(PA, 9'd21, 2'd1, 2'd0, 1'b1);
    wait_done(12, got);
    chk(!got && cas_cnt == 0, "R8", "dirty store held", 64'(cas_cnt) | 64'(got), 64'd0);
    store_nonspec = 1;
    wait_done(20, got);
    chk(got && done_status == 0 && mem_arr[5] == PAD, "R8", "dirty store released", mem_arr[5], PAD);
    @(negedge clk);

    // R8: A-only update from a store is not held
    store_nonspec = 0;
    start(PD, 9'd22, 2'd1, 2'd0, 1'b1);
    wait_done(12, got);
    chk(got && mem_arr[6] == PAD, "R8", "accessed-only store not held", mem_arr[6], PAD);
    @(negedge clk);
    store_nonspec = 1;

    // R6: lost swap, re-read, retry
    interf_val = P | 64'h100; interf_en = 1;
    start(P, 9'd23, 2'd0, 2'd0, 1'b1);
    wait_done(40, got);
    chk(got && done_status == 0 && mem_arr[7] == (P | 64'h140), "R6", "retry after lost swap",
        mem_arr[7], P | 64'h140);
    chk(cas_cnt == 2 && rd_cnt == 1, "R6", "swap/read counts", 64'(cas_cnt * 16 + rd_cnt), 64'd33);
    chk(done_pte == (P | 64'h140), "R9", "final pte after retry", done_pte, P | 64'h140);
    @(negedge clk);

    // R6: other writer already set A, no second swap
    interf_val = PA; interf_en = 1;
    start(P, 9'd24, 2'd0, 2'd0, 1'b1);
    wait_done(40, got);
    chk(got && done_status == 0 && cas_cnt == 1 && rd_cnt == 1, "R6", "recheck finds A set",
        64'(cas_cnt * 16 + rd_cnt), 64'd17);
    @(negedge clk);

    // R7: re-read returns an invalid entry
    interf_val = P0; interf_en = 1;
    start(P, 9'd25, 2'd0, 2'd0, 1'b1);
    wait_done(40, got);
    chk(got && done_status == 1, "R7", "invalid after re-read", 64'(done_status), 64'd1);
    chk(mem_arr[1] == P0 && cas_cnt == 1, "R7", "no write after invalid", mem_arr[1], P0);
    @(negedge clk);

    wrap_up();
  end
endmodule